// File: doc/BRIEF.md
# Circular Trace Capture Buffer

This block is the sample store of an acquisition engine that watches a stream of data words. Each clock it may receive one sample, a store qualifier and a trigger pulse, all decided by logic outside the block. Qualified samples go into a circular RAM. Once the RAM has filled, each new sample overwrites the oldest one. When the trigger pulse arrives, the sample of that cycle becomes the trigger sample. Capture then goes on until the trigger sample sits at the position the host chose, and at that point the block halts and reports completion.

The host sets the position by choosing how many stored samples should precede the trigger sample. Placing the trigger in the middle means driving half the depth. A pulse on the arm input latches that count, clears every pointer and flag, and starts a run. After the run, the host unloads the buffer through a read port whose index counts from the oldest valid entry, so that index 0 is the earliest sample kept. The block reports three values for interpreting the data: the number of valid entries, whether the buffer wrapped, and the RAM address that holds the trigger sample.

The controller has four states:
- `ST_IDLE`: the state after reset.
- `ST_PRE`: filling and wrapping while no trigger has arrived.
- `ST_POST`: counting down the samples after the trigger.
- `ST_HALT`: run complete.

The transitions are:
- arm: from any state to `ST_PRE`.
- trigger: from `ST_PRE` to `ST_POST`, or straight to `ST_HALT` when no further samples are owed.
- last post sample: from `ST_POST` to `ST_HALT`.

Top module: `trace_ring_capture`

## Requirements
- R1: After reset, `capturing`, `triggered`, `done` and `full` are 0 and `valid_count` is 0. Samples presented before the first arm are not stored.
- R2: An arm pulse clears `triggered`, `done`, `full`, `trig_addr` and `valid_count` at the next clock, sets `capturing`, and latches `pre_count`. A sample presented with `smp_store`=0 and `smp_trig`=0 is not stored.
- R3: While capturing, each sample with `smp_store`=1 is written at the next address in sequence, and `valid_count` rises by one per stored sample until the buffer is full.
- R4: After DEPTH stored samples, `full` is 1 and `valid_count` stays at DEPTH. Each further sample replaces the oldest entry, and `full` stays set until the next arm.
- R5: The first `smp_trig` pulse of a run stores that cycle's sample whatever `smp_store` is. It sets `triggered` and latches `trig_addr`, the RAM address of that sample, which is the count of samples stored before it, modulo DEPTH.
- R6: After the trigger sample, exactly DEPTH-1-P further samples with `smp_store`=1 are stored, where P is the latched `pre_count`. The clock edge that stores the last of them sets `done`. Samples with `smp_store`=0 are not counted.
- R7: A trigger pulse after the first trigger of a run changes neither `trig_addr` nor the stored data. It does not store its sample unless `smp_store` is 1.
- R8: If no trigger arrives, the buffer keeps wrapping, `capturing` stays 1 and `done` stays 0.
- R9: Once `done` is 1, no sample is stored. `valid_count`, `trig_addr` and the buffer contents hold until the next arm.
- R10: A read with `rd_en`=1 and index i returns, one clock later with `rd_valid`=1, the i-th oldest valid entry. Index 0 is the oldest entry: address 0 if the buffer never wrapped, otherwise the next write address. `rd_valid` is 0 in the clock after a cycle with `rd_en`=0.
- R11: With P = DEPTH-1, `done` is set on the same edge that stores the trigger sample, which leaves the trigger sample as the newest entry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| arm | input | 1 | Start a new run; clears pointers and flags |
| pre_count | input | AW | Samples wanted before the trigger, latched at arm |
| smp_data | input | SAMPLE_W | Sample word |
| smp_store | input | 1 | Store qualifier for this cycle's sample |
| smp_trig | input | 1 | Trigger pulse for this cycle's sample |
| rd_en | input | 1 | Read request |
| rd_idx | input | AW | Read index counted from the oldest valid entry |
| rd_data | output | SAMPLE_W | Read data, one clock after the request |
| rd_valid | output | 1 | rd_data carries a result |
| capturing | output | 1 | Run in progress (pre or post trigger) |
| triggered | output | 1 | Trigger accepted in this run |
| done | output | 1 | Run complete |
| full | output | 1 | Buffer has wrapped |
| valid_count | output | AW+1 | Number of valid entries |
| trig_addr | output | AW | RAM address of the trigger sample |

## Verification
The assertions assume that `arm` is the only way to leave the halted state, and that `rd_en` is a plain request with no other handshake. The stimulus keeps to this by pulsing arm for one cycle only between runs and by reading back only after `done` is set. The flag and counter properties also assume that reset is applied once before the first arm, and the bench does so. Trigger pulses are driven while capturing and also after the first trigger, so that a second trigger in the same run is seen to be ignored.

// File: rtl/trc_pkg.sv
package trc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_PRE  = 2'd1,
        ST_POST = 2'd2,
        ST_HALT = 2'd3
    } cap_state_e;

endpackage

// File: rtl/trc_ring_mem.sv
module trc_ring_mem #(
    parameter int WIDTH = 16,
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic             re,
    input  logic [AW-1:0]    raddr,
    output logic [WIDTH-1:0] rdata
);

    logic [WIDTH-1:0] store_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            store_q[waddr] <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (re) begin
            rdata <= store_q[raddr];
        end
    end

endmodule

// File: rtl/trc_cap_ctrl.sv
module trc_cap_ctrl
    import trc_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          arm,
    input  logic [AW-1:0] pre_count,
    input  logic          smp_store,
    input  logic          smp_trig,
    output logic          wr_en,
    output logic [AW-1:0] wr_addr,
    output logic [AW-1:0] oldest_addr,
    output logic [CW-1:0] valid_count,
    output logic [AW-1:0] trig_addr,
    output logic          capturing,
    output logic          triggered,
    output logic          done,
    output logic          full
);

    localparam logic [AW-1:0] LAST_ADDR = AW'(DEPTH - 1);

    cap_state_e    state_q, state_d;
    logic [AW-1:0] wptr_q;
    logic [AW-1:0] pre_q;
    logic [AW-1:0] remain_q;
    logic [AW-1:0] taddr_q;
    logic          full_q;
    logic          trig_q;
    logic [AW-1:0] post_len;
    logic          take_trig;
    logic          post_store;

    // samples still owed after the trigger sample itself
    assign post_len   = LAST_ADDR - pre_q;
    assign take_trig  = (state_q == ST_PRE) && smp_trig && !arm;
    assign post_store = (state_q == ST_POST) && smp_store && !arm;

    // next-state decision
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (arm) state_d = ST_PRE;
            end
            ST_PRE: begin
                if (arm) begin
                    state_d = ST_PRE;
                end else if (smp_trig) begin
                    state_d = (post_len == '0) ? ST_HALT : ST_POST;
                end
            end
            ST_POST: begin
                if (arm) begin
                    state_d = ST_PRE;
                end else if (smp_store && remain_q == AW'(1)) begin
                    state_d = ST_HALT;
                end
            end
            ST_HALT: begin
                if (arm) state_d = ST_PRE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // pointers, flags and counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wptr_q   <= '0;
            pre_q    <= '0;
            remain_q <= '0;
            taddr_q  <= '0;
            full_q   <= 1'b0;
            trig_q   <= 1'b0;
        end else if (arm) begin
            wptr_q   <= '0;
            pre_q    <= pre_count;
            remain_q <= '0;
            taddr_q  <= '0;
            full_q   <= 1'b0;
            trig_q   <= 1'b0;
        end else begin
            if (wr_en) begin
                wptr_q <= wptr_q + AW'(1);
                if (wptr_q == LAST_ADDR) begin
                    full_q <= 1'b1;
                end
            end
            if (take_trig) begin
                trig_q   <= 1'b1;
                taddr_q  <= wptr_q;
                remain_q <= post_len;
            end else if (post_store) begin
                remain_q <= remain_q - AW'(1);
            end
        end
    end

    // outputs
    always_comb begin
        wr_en     = 1'b0;
        capturing = 1'b0;
        done      = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_PRE: begin
                capturing = 1'b1;
                wr_en     = !arm && (smp_store || smp_trig);
            end
            ST_POST: begin
                capturing = 1'b1;
                wr_en     = post_store;
            end
            ST_HALT: begin
                done = 1'b1;
            end
            default: ;
        endcase
        wr_addr     = wptr_q;
        oldest_addr = full_q ? wptr_q : '0;
        valid_count = full_q ? CW'(DEPTH) : {1'b0, wptr_q};
        trig_addr   = taddr_q;
        triggered   = trig_q;
        full        = full_q;
    end

endmodule

// File: rtl/trc_rd_port.sv
module trc_rd_port #(
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd_en,
    input  logic [AW-1:0] rd_idx,
    input  logic [AW-1:0] oldest_addr,
    output logic          mem_re,
    output logic [AW-1:0] mem_raddr,
    output logic          rd_valid
);

    // index is relative to the oldest entry; the modulo is the natural wrap
    assign mem_re    = rd_en;
    assign mem_raddr = oldest_addr + rd_idx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
        end else begin
            rd_valid <= rd_en;
        end
    end

endmodule

// File: rtl/trace_ring_capture.sv
module trace_ring_capture #(
    parameter int SAMPLE_W = 16,
    parameter int DEPTH    = 16,
    localparam int AW      = $clog2(DEPTH),
    localparam int CW      = AW + 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                arm,
    input  logic [AW-1:0]       pre_count,
    input  logic [SAMPLE_W-1:0] smp_data,
    input  logic                smp_store,
    input  logic                smp_trig,
    input  logic                rd_en,
    input  logic [AW-1:0]       rd_idx,
    output logic [SAMPLE_W-1:0] rd_data,
    output logic                rd_valid,
    output logic                capturing,
    output logic                triggered,
    output logic                done,
    output logic                full,
    output logic [CW-1:0]       valid_count,
    output logic [AW-1:0]       trig_addr
);

    logic          wr_en;
    logic [AW-1:0] wr_addr;
    logic [AW-1:0] oldest_addr;
    logic          mem_re;
    logic [AW-1:0] mem_raddr;

    trc_cap_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .arm         (arm),
        .pre_count   (pre_count),
        .smp_store   (smp_store),
        .smp_trig    (smp_trig),
        .wr_en       (wr_en),
        .wr_addr     (wr_addr),
        .oldest_addr (oldest_addr),
        .valid_count (valid_count),
        .trig_addr   (trig_addr),
        .capturing   (capturing),
        .triggered   (triggered),
        .done        (done),
        .full        (full)
    );

    trc_rd_port #(.DEPTH(DEPTH)) u_rd (
        .clk         (clk),
        .rst_n       (rst_n),
        .rd_en       (rd_en),
        .rd_idx      (rd_idx),
        .oldest_addr (oldest_addr),
        .mem_re      (mem_re),
        .mem_raddr   (mem_raddr),
        .rd_valid    (rd_valid)
    );

    trc_ring_mem #(.WIDTH(SAMPLE_W), .DEPTH(DEPTH)) u_mem (
        .clk   (clk),
        .we    (wr_en),
        .waddr (wr_addr),
        .wdata (smp_data),
        .re    (mem_re),
        .raddr (mem_raddr),
        .rdata (rd_data)
    );

endmodule

// File: rtl/trc_checker.sv
module trc_checker #(
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = AW + 1
) (
    input logic          clk,
    input logic          rst_n,
    input logic          arm,
    input logic          rd_en,
    input logic          capturing,
    input logic          triggered,
    input logic          done,
    input logic          full,
    input logic [CW-1:0] valid_count,
    input logic [AW-1:0] trig_addr,
    input logic          rd_valid
);

    assert_arm_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
        arm |=> (capturing && !triggered && !done && !full && valid_count == '0));

    assert_idle_no_store_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!capturing && !arm) |=> $stable(valid_count));

    assert_full_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !arm) |=> full);

    assert_trig_addr_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (triggered && !arm) |=> ($stable(trig_addr) && triggered));

    assert_done_needs_trig_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (triggered && !capturing));

    assert_done_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !arm) |=> (done && $stable(valid_count) && $stable(trig_addr)));

    assert_rd_valid_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rd_valid);

    assert_rd_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> !rd_valid);

endmodule

bind trace_ring_capture trc_checker #(.DEPTH(DEPTH)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .arm         (arm),
    .rd_en       (rd_en),
    .capturing   (capturing),
    .triggered   (triggered),
    .done        (done),
    .full        (full),
    .valid_count (valid_count),
    .trig_addr   (trig_addr),
    .rd_valid    (rd_valid)
);

// File: tb/sim_trace_ring_capture.sv
module sim_trace_ring_capture;

    localparam int SW = 16;
    localparam int DEPTH = 16;
    localparam int AW = $clog2(DEPTH);
    localparam int CW = AW + 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          arm = 1'b0;
    logic [AW-1:0] pre_count = '0;
    logic [SW-1:0] smp_data = '0;
    logic          smp_store = 1'b0;
    logic          smp_trig = 1'b0;
    logic          rd_en = 1'b0;
    logic [AW-1:0] rd_idx = '0;
    logic [SW-1:0] rd_data;
    logic          rd_valid;
    logic          capturing, triggered, done, full;
    logic [CW-1:0] valid_count;
    logic [AW-1:0] trig_addr;

    trace_ring_capture #(.SAMPLE_W(SW), .DEPTH(DEPTH)) u0 (
        .clk(clk), .rst_n(rst_n), .arm(arm), .pre_count(pre_count),
        .smp_data(smp_data), .smp_store(smp_store), .smp_trig(smp_trig),
        .rd_en(rd_en), .rd_idx(rd_idx), .rd_data(rd_data), .rd_valid(rd_valid),
        .capturing(capturing), .triggered(triggered), .done(done), .full(full),
        .valid_count(valid_count), .trig_addr(trig_addr)
    );

    always #5 clk = ~clk;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit finished = 0;

    // reference model
    int mstate = 0;            // 0 idle, 1 pre, 2 post, 3 halt
    int mw = 0;
    int mpre = 0;
    int mrem = 0;
    int mtaddr = 0;
    logic [SW-1:0] mq[$];
    logic [SW-1:0] exp_q[$];
    logic [SW-1:0] seed = 16'h1234;

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic m_store(logic [SW-1:0] d);
        mq.push_back(d);
        if (mq.size() > DEPTH) void'(mq.pop_front());
        mw = (mw + 1) % DEPTH;
    endtask

    task automatic drive(logic [SW-1:0] d, bit s, bit t);
        @(negedge clk);
        smp_data = d; smp_store = s; smp_trig = t;
        @(posedge clk);
        if (mstate == 1) begin
            if (t) begin
                mtaddr = mw;
                m_store(d);
                mrem = DEPTH - 1 - mpre;
                mstate = (mrem == 0) ? 3 : 2;
            end else if (s) begin
                m_store(d);
            end
        end else if (mstate == 2 && s) begin
            m_store(d);
            mrem--;
            if (mrem == 0) mstate = 3;
        end
        #1;
        smp_store = 1'b0; smp_trig = 1'b0;
    endtask

    task automatic stored_run(int n);
        for (int i = 0; i < n; i++) begin
            seed = seed * 16'd25173 + 16'd13849;
            drive(seed, 1'b1, 1'b0);
        end
    endtask

    task automatic do_arm(int p);
        @(negedge clk);
        arm = 1'b1; pre_count = AW'(p);
        @(posedge clk);
        mstate = 1; mw = 0; mpre = p; mrem = 0; mtaddr = 0;
        mq.delete();
        #1;
        arm = 1'b0;
    endtask

    task automatic readback();
        for (int i = 0; i < mq.size(); i++) begin
            @(negedge clk);
            rd_en = 1'b1; rd_idx = AW'(i);
            exp_q.push_back(mq[i]);
            @(posedge clk);
            #1;
            rd_en = 1'b0;
        end
        @(negedge clk);
        @(negedge clk);
        check("R10 outstanding reads", exp_q.size(), 0);
    endtask

    // monitor: pops expected read data as results appear
    always @(negedge clk) begin
        if (rd_valid) begin
            if (exp_q.size() == 0) begin
                check("R10 unexpected rd_valid", 1, 0);
            end else begin
                check("R10 read data", int'(rd_data), int'(exp_q.pop_front()));
            end
        end
    end

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            checks++; errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
            summary();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 capturing", int'(capturing), 0);
        check("R1 triggered", int'(triggered), 0);
        check("R1 done", int'(done), 0);
        check("R1 full", int'(full), 0);
        check("R1 valid_count", int'(valid_count), 0);
        drive(16'hAAAA, 1'b1, 1'b1);
        @(negedge clk);
        check("R1 no store before arm", int'(valid_count), 0);
        check("R1 no trigger before arm", int'(triggered), 0);

        // Run A: middle trigger position, wrapped buffer
        do_arm(DEPTH / 2);
        @(negedge clk);
        check("R2 capturing after arm", int'(capturing), 1);
        stored_run(5);
        drive(16'h0BAD, 1'b0, 1'b0);
        drive(16'h0BAD, 1'b0, 1'b0);
        @(negedge clk);
        check("R2 unqualified not stored", int'(valid_count), 5);
        check("R3 count", int'(valid_count), mq.size());
        stored_run(20);
        @(negedge clk);
        check("R4 full", int'(full), 1);
        check("R4 valid_count saturates", int'(valid_count), DEPTH);
        check("R8 not done without trigger", int'(done), 0);
        drive(16'h7777, 1'b0, 1'b1);
        @(negedge clk);
        check("R5 triggered", int'(triggered), 1);
        check("R5 trig_addr", int'(trig_addr), 25 % DEPTH);
        check("R5 trig_addr model", int'(trig_addr), mtaddr);
        drive(16'h5A5A, 1'b0, 1'b1);
        drive(16'h5A5A, 1'b0, 1'b1);
        drive(16'h5A5A, 1'b0, 1'b1);
        @(negedge clk);
        check("R7 second trigger ignored", int'(trig_addr), 25 % DEPTH);
        check("R6 unqualified not counted", int'(done), 0);
        stored_run(DEPTH - 1 - DEPTH / 2 - 1);
        @(negedge clk);
        check("R6 not yet done", int'(done), 0);
        stored_run(1);
        @(negedge clk);
        check("R6 done after post count", int'(done), 1);
        stored_run(4);
        drive(16'h1111, 1'b1, 1'b1);
        @(negedge clk);
        check("R9 done holds", int'(done), 1);
        check("R9 count frozen", int'(valid_count), DEPTH);
        check("R9 trig_addr frozen", int'(trig_addr), 25 % DEPTH);
        check("R6 trigger position", (int'(trig_addr) - mw + DEPTH) % DEPTH, DEPTH / 2);
        readback();

        // Run B: trigger as newest entry, buffer not wrapped
        do_arm(DEPTH - 1);
        stored_run(3);
        drive(16'h00EE, 1'b0, 1'b1);
        @(negedge clk);
        check("R11 done on trigger edge", int'(done), 1);
        check("R11 trig_addr", int'(trig_addr), 3);
        check("R11 not full", int'(full), 0);
        check("R11 count", int'(valid_count), 4);
        readback();

        // Run C: trigger as oldest entry
        do_arm(0);
        drive(16'h0C0C, 1'b1, 1'b1);
        stored_run(DEPTH - 2);
        @(negedge clk);
        check("R6 zero pre not done", int'(done), 0);
        stored_run(1);
        @(negedge clk);
        check("R6 zero pre done", int'(done), 1);
        check("R6 zero pre trig_addr", int'(trig_addr), 0);
        check("R4 full at end", int'(full), 1);
        readback();

        // Run D: no trigger ever
        do_arm(4);
        stored_run(3 * DEPTH + 3);
        @(negedge clk);
        check("R8 still capturing", int'(capturing), 1);
        check("R8 never done", int'(done), 0);
        check("R8 full", int'(full), 1);
        do_arm(4);
        @(negedge clk);
        check("R2 rearm clears full", int'(full), 0);
        check("R2 rearm clears count", int'(valid_count), 0);
        check("R2 rearm clears trig_addr", int'(trig_addr), 0);

        repeat (3) @(negedge clk);
        summary();
    end

endmodule